// File: doc/BRIEF.md
# Timer Burst Access Redirector

This block sits in the register decoder of a timer peripheral. It lets a DMA engine move a run of consecutive timer registers through one fixed window address. A configuration register holds a 5-bit first-register index and a 5-bit run length. Each word access to the window address is sent to the timer register at byte offset `(first + step) * 4`. Here `step` is a hidden counter that starts at zero and goes up by one after each access. Once the counter has covered `length + 1` registers it returns to zero, so the DMA engine can repeat the run without reprogramming.

All other addresses pass straight through to the timer register file. The translation is combinational, so a redirected access reaches the register file in the same cycle it is presented. The counter moves on the clock edge that ends the access.

Top module: `tmr_burst_redir`

## Requirements
- R1: After reset the configuration register reads as zero, the hidden counter is zero, and the first window access targets byte offset 0x00.
- R2: A word access (`bus_size` = 2'b10) to the window offset 0xE4 drives `rf_addr` = (first + step) * 4. It raises `rf_wr` for a write and `rf_rd` for a read. When `bus_wr` and `bus_rd` are both high, the write takes precedence and `rf_rd` stays low.
- R3: The counter advances by one on each word window access. After the access made with step equal to the run length, it returns to 0, so a run covers length + 1 registers.
- R4: A word write to the configuration offset 0xE0 loads first from bits 4:0 and length from bits 12:8, and clears the counter to 0. A non-word write there changes nothing.
- R5: A length value above 17 is stored as 17.
- R6: A read of the configuration offset returns first in bits 4:0 and length in bits 12:8, with every other bit zero. Configuration accesses never raise `rf_wr` or `rf_rd`.
- R7: A window read returns `rf_rdata` zero-extended, so bits 31:16 are zero. A window write passes `bus_wdata[15:0]` on `rf_wdata`.
- R8: When first + step is not below the implemented register count (20), the window access raises no strobe and reads zero, but the counter still advances or wraps.
- R9: A non-word access to the window offset raises no strobe, reads zero, and leaves the counter unchanged.
- R10: Any other address passes through unchanged to `rf_addr` with matching strobes, and a read returns `rf_rdata` zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the bus access |
| bus_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is served |
| rf_addr | output | 8 | Byte address presented to the timer register file |
| rf_wr | output | 1 | Register file write strobe |
| rf_rd | output | 1 | Register file read strobe |
| rf_wdata | output | 16 | Register file write data |
| rf_rdata | input | 16 | Register file read data |

## Verification
The counter wrap and the out-of-window suppression can fall on the same access. This happens when the last step of a run points past the implemented registers. The bench provokes it by placing the first index near the top of the window with a length that runs beyond it. The reference model then expects no strobe and zero read data on that access, and a return to the first index on the next one. A second collision is a configuration rewrite in the middle of a run: the counter clear must take effect on the very next window access, whatever step the counter had reached.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

   localparam int unsigned FIELD_W = 5;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } bus_size_e;

   typedef struct packed {
      logic [FIELD_W-1:0] len;
      logic [FIELD_W-1:0] first;
   } burst_cfg_t;

   function automatic logic [FIELD_W-1:0] limit_len(
      input logic [FIELD_W-1:0] raw,
      input int unsigned        max_len
   );
      return (int'(raw) > int'(max_len)) ? FIELD_W'(max_len) : raw;
   endfunction

endpackage

// File: rtl/tbr_cfg_reg.sv
module tbr_cfg_reg
   import tbr_pkg::*;
#(
   parameter int unsigned MAX_LEN  = 17,
   parameter bit          CLAMP_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [FIELD_W-1:0] first_in,
   input  logic [FIELD_W-1:0] len_in,
   output burst_cfg_t         cfg
);

   logic [FIELD_W-1:0] len_next;

   generate
      if (CLAMP_EN) begin : g_clamp
         assign len_next = limit_len(len_in, MAX_LEN);
      end else begin : g_raw
         assign len_next = len_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (we) begin
         cfg.first <= first_in;
         cfg.len   <= len_next;
      end
   end

endmodule

// File: rtl/tbr_index.sv
module tbr_index
   import tbr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               step,
   input  logic [FIELD_W-1:0] limit,
   output logic [FIELD_W-1:0] idx
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clr) begin
         idx <= '0;
      end else if (step) begin
         idx <= (idx >= limit) ? '0 : idx + 1'b1;
      end
   end

endmodule

// File: rtl/tbr_xlate.sv
module tbr_xlate
   import tbr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned NUM_REGS = 20
) (
   input  logic [FIELD_W-1:0] first,
   input  logic [FIELD_W-1:0] idx,
   output logic [ADDR_W-1:0]  tgt_addr,
   output logic               in_win
);

   localparam int unsigned SUM_W   = FIELD_W + 1;
   localparam int unsigned SUM_MAX = (1 << SUM_W);
   localparam int unsigned PAD_W   = ADDR_W - SUM_W - 2;

   logic [SUM_W-1:0] sum;

   assign sum = {1'b0, first} + {1'b0, idx};

   generate
      if (ADDR_W < SUM_W + 2) begin : g_bad_addr_w
         $error("tbr_xlate: ADDR_W too narrow for the translated offset");
      end
      if (NUM_REGS * 4 > (1 << ADDR_W)) begin : g_bad_regs
         $error("tbr_xlate: NUM_REGS does not fit in the address space");
      end

      if (ADDR_W == SUM_W + 2) begin : g_exact
         assign tgt_addr = {sum, 2'b00};
      end else begin : g_pad
         assign tgt_addr = {{PAD_W{1'b0}}, sum, 2'b00};
      end

      if (NUM_REGS >= SUM_MAX) begin : g_full_win
         assign in_win = 1'b1;
      end else begin : g_part_win
         assign in_win = (int'(sum) < int'(NUM_REGS));
      end
   endgenerate

endmodule

// File: rtl/tmr_burst_redir.sv
module tmr_burst_redir
   import tbr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned REG_W    = 16,
   parameter int unsigned NUM_REGS = 20,
   parameter int unsigned MAX_LEN  = 17,
   parameter int unsigned LEN_LSB  = 8,
   parameter bit          CLAMP_EN = 1'b1,
   parameter logic [7:0]  CFG_OFS  = 8'hE0,
   parameter logic [7:0]  BUF_OFS  = 8'hE4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] rf_addr,
   output logic              rf_wr,
   output logic              rf_rd,
   output logic [REG_W-1:0]  rf_wdata,
   input  logic [REG_W-1:0]  rf_rdata
);

   localparam int unsigned HI_W = DATA_W - REG_W;

   generate
      if (REG_W > DATA_W) begin : g_bad_reg_w
         $error("tmr_burst_redir: REG_W wider than DATA_W");
      end
      if (LEN_LSB + FIELD_W > DATA_W || LEN_LSB < FIELD_W) begin : g_bad_lsb
         $error("tmr_burst_redir: length field position invalid");
      end
      if (MAX_LEN >= (1 << FIELD_W)) begin : g_bad_max
         $error("tmr_burst_redir: MAX_LEN exceeds field range");
      end
   endgenerate

   logic               hit_buf;
   logic               hit_cfg;
   logic               is_word;
   logic               rd_only;
   logic               buf_go;
   logic               cfg_we;
   logic               in_win;
   logic [ADDR_W-1:0]  tgt_addr;
   logic [FIELD_W-1:0] idx_q;
   burst_cfg_t         cfg_q;
   logic [DATA_W-1:0]  cfg_rb;

   assign hit_buf = (bus_addr == ADDR_W'(BUF_OFS));
   assign hit_cfg = (bus_addr == ADDR_W'(CFG_OFS));
   assign is_word = (bus_size == SZ_WORD);
   assign rd_only = bus_rd & ~bus_wr;
   assign buf_go  = hit_buf & is_word & (bus_wr | bus_rd);
   assign cfg_we  = hit_cfg & is_word & bus_wr;

   tbr_cfg_reg #(
      .MAX_LEN  (MAX_LEN),
      .CLAMP_EN (CLAMP_EN)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .first_in (bus_wdata[FIELD_W-1:0]),
      .len_in   (bus_wdata[LEN_LSB +: FIELD_W]),
      .cfg      (cfg_q)
   );

   tbr_index u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cfg_we),
      .step  (buf_go),
      .limit (cfg_q.len),
      .idx   (idx_q)
   );

   tbr_xlate #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS)
   ) u_xlate (
      .first    (cfg_q.first),
      .idx      (idx_q),
      .tgt_addr (tgt_addr),
      .in_win   (in_win)
   );

   always_comb begin
      cfg_rb = '0;
      cfg_rb[FIELD_W-1:0]       = cfg_q.first;
      cfg_rb[LEN_LSB +: FIELD_W] = cfg_q.len;
   end

   always_comb begin
      if (hit_buf) begin
         rf_addr = tgt_addr;
         rf_wr   = buf_go & in_win & bus_wr;
         rf_rd   = buf_go & in_win & rd_only;
      end else begin
         rf_addr = bus_addr;
         rf_wr   = ~hit_cfg & bus_wr;
         rf_rd   = ~hit_cfg & rd_only;
      end
   end

   assign rf_wdata = bus_wdata[REG_W-1:0];

   always_comb begin
      if (hit_cfg && rd_only) begin
         bus_rdata = cfg_rb;
      end else if (rf_rd) begin
         bus_rdata = {{HI_W{1'b0}}, rf_rdata};
      end else begin
         bus_rdata = '0;
      end
   end

endmodule

// File: rtl/tbr_checker.sv
module tbr_checker
   import tbr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned REG_W    = 16,
   parameter int unsigned MAX_LEN  = 17,
   parameter bit          CLAMP_EN = 1'b1,
   parameter logic [7:0]  CFG_OFS  = 8'hE0,
   parameter logic [7:0]  BUF_OFS  = 8'hE4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [1:0]         bus_size,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               rf_wr,
   input logic               rf_rd,
   input logic [FIELD_W-1:0] idx,
   input logic [FIELD_W-1:0] len
);

   logic at_buf;
   logic at_cfg;
   logic word;

   assign at_buf = (bus_addr == ADDR_W'(BUF_OFS));
   assign at_cfg = (bus_addr == ADDR_W'(CFG_OFS));
   assign word   = (bus_size == SZ_WORD);

   p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rf_wr, rf_rd}));

   p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= len);

   p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (at_buf && word && (bus_wr || bus_rd) && idx < len)
      |=> idx == $past(idx) + 1'b1);

   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (at_buf && word && (bus_wr || bus_rd) && idx == len)
      |=> idx == '0);

   p_cfg_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (at_cfg && word && bus_wr) |=> idx == '0);

   p_cfg_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      at_cfg |-> (!rf_wr && !rf_rd));

   p_rdata_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (at_buf && bus_rd) |-> bus_rdata[DATA_W-1:REG_W] == '0);

   p_nonword_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (at_buf && !word) |-> (!rf_wr && !rf_rd && bus_rdata == '0));

   p_nonword_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (at_buf && !word) |=> $stable(idx));

   generate
      if (CLAMP_EN) begin : g_clamp_chk
         p_len_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            int'(len) <= int'(MAX_LEN));
      end
   endgenerate

endmodule

bind tmr_burst_redir tbr_checker #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .REG_W    (REG_W),
   .MAX_LEN  (MAX_LEN),
   .CLAMP_EN (CLAMP_EN),
   .CFG_OFS  (CFG_OFS),
   .BUF_OFS  (BUF_OFS)
) u_tbr_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_size  (bus_size),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .rf_wr     (rf_wr),
   .rf_rd     (rf_rd),
   .idx       (idx_q),
   .len       (cfg_q.len)
);

// File: tb/tb_tmr_burst_redir.sv
module tb_tmr_burst_redir;

   localparam logic [7:0] CFG = 8'hE0;
   localparam logic [7:0] BUF = 8'hE4;
   localparam logic [1:0] WD  = 2'b10;
   localparam int         NREGS = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [1:0]  bus_size = WD;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  rf_addr;
   logic        rf_wr;
   logic        rf_rd;
   logic [15:0] rf_wdata;
   logic [15:0] rf_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int m_first = 0;
   int m_len   = 0;
   int m_idx   = 0;

   always #4 clk = ~clk;

   // stand-in register file: read value derived from the address
   assign rf_rdata = 16'hA500 ^ {8'h00, rf_addr};

   tmr_burst_redir dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rf_addr   (rf_addr),
      .rf_wr     (rf_wr),
      .rf_rd     (rf_rd),
      .rf_wdata  (rf_wdata),
      .rf_rdata  (rf_rdata)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one bus cycle against the behavioural reference model
   task automatic acc(input logic [7:0] a, input logic [1:0] sz, input bit w,
                      input bit r, input logic [31:0] wd, input string req);
      bit          e_wr, e_rd, word, ronly;
      logic [7:0]  e_addr;
      logic [31:0] e_rdata;
      int          sum, n_first, n_len, n_idx;
      @(negedge clk);
      bus_addr = a; bus_size = sz; bus_wr = w; bus_rd = r; bus_wdata = wd;
      #2;
      word = (sz == WD);
      ronly = r && !w;
      n_first = m_first; n_len = m_len; n_idx = m_idx;
      e_wr = 1'b0; e_rd = 1'b0; e_addr = a; e_rdata = '0;
      if (a == BUF) begin
         sum = m_first + m_idx;
         e_addr = 8'(sum * 4);
         if (word && (w || r)) begin
            e_wr = w && (sum < NREGS);
            e_rd = ronly && (sum < NREGS);
            n_idx = (m_idx == m_len) ? 0 : m_idx + 1;
         end
         if (e_rd) e_rdata = {16'h0, 16'hA500 ^ {8'h00, e_addr}};
      end else if (a == CFG) begin
         if (ronly) e_rdata = 32'((m_len << 8) | m_first);
         if (w && word) begin
            n_first = int'(wd[4:0]);
            n_len   = (int'(wd[12:8]) > 17) ? 17 : int'(wd[12:8]);
            n_idx   = 0;
         end
      end else begin
         e_wr = w;
         e_rd = ronly;
         if (e_rd) e_rdata = {16'h0, 16'hA500 ^ {8'h00, a}};
      end
      chk(rf_wr == e_wr, req, "rf_wr", 32'(rf_wr), 32'(e_wr));
      chk(rf_rd == e_rd, req, "rf_rd", 32'(rf_rd), 32'(e_rd));
      chk(bus_rdata == e_rdata, req, "bus_rdata", bus_rdata, e_rdata);
      if (e_wr || e_rd)
         chk(rf_addr == e_addr, req, "rf_addr", 32'(rf_addr), 32'(e_addr));
      if (e_wr)
         chk(rf_wdata == wd[15:0], req, "rf_wdata", 32'(rf_wdata), 32'(wd[15:0]));
      @(posedge clk);
      m_first = n_first; m_len = n_len; m_idx = n_idx;
   endtask

   task automatic idle(input string req);
      acc(8'h00, WD, 1'b0, 1'b0, 32'h0, req);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      idle("R1");
      acc(CFG, WD, 1'b0, 1'b1, 32'h0, "R1");
      acc(BUF, WD, 1'b0, 1'b1, 32'h0, "R1");
      acc(BUF, WD, 1'b0, 1'b1, 32'h0, "R1");

      // R4 / R6: program first=3 len=2, reserved bits set in the write
      acc(CFG, WD, 1'b1, 1'b0, 32'hFFFF_02E3, "R4");
      acc(CFG, WD, 1'b0, 1'b1, 32'h0, "R6");

      // R2 / R7: writes walk 0x0C,0x10,0x14 then wrap
      for (int i = 0; i < 4; i++)
         acc(BUF, WD, 1'b1, 1'b0, 32'h1234_AB00 + 32'(i), "R2");
      for (int i = 0; i < 3; i++)
         acc(BUF, WD, 1'b0, 1'b1, 32'h0, "R7");

      // R5 / R3: oversize length clamps to 17, full 18-register run then wrap
      acc(CFG, WD, 1'b1, 1'b0, 32'h0000_1F00, "R5");
      acc(CFG, WD, 1'b0, 1'b1, 32'h0, "R5");
      for (int i = 0; i < 19; i++)
         acc(BUF, WD, 1'b0, 1'b1, 32'h0, "R3");

      // R8: run crosses the top of the window, wrap lands on a dropped step
      acc(CFG, WD, 1'b1, 1'b0, 32'h0000_0411, "R8");
      for (int i = 0; i < 6; i++)
         acc(BUF, WD, i[0], !i[0], 32'h0000_5A00 + 32'(i), "R8");

      // R9: non-word window accesses are dropped and hold the counter
      acc(CFG, WD, 1'b1, 1'b0, 32'h0000_0302, "R9");
      acc(BUF, WD, 1'b0, 1'b1, 32'h0, "R9");
      acc(BUF, 2'b00, 1'b0, 1'b1, 32'h0, "R9");
      acc(BUF, 2'b01, 1'b1, 1'b0, 32'h0000_7777, "R9");
      acc(BUF, WD, 1'b0, 1'b1, 32'h0, "R9");

      // R4: non-word config write ignored; mid-run config write clears counter
      acc(CFG, 2'b01, 1'b1, 1'b0, 32'h0000_0105, "R4");
      acc(CFG, WD, 1'b0, 1'b1, 32'h0, "R4");
      acc(BUF, WD, 1'b0, 1'b1, 32'h0, "R4");
      acc(CFG, WD, 1'b1, 1'b0, 32'h0000_0302, "R4");
      acc(BUF, WD, 1'b0, 1'b1, 32'h0, "R4");

      // R10: pass-through, including write precedence
      acc(8'h08, WD, 1'b1, 1'b0, 32'hDEAD_BEEF, "R10");
      acc(8'h4C, WD, 1'b0, 1'b1, 32'h0, "R10");
      acc(8'h10, WD, 1'b1, 1'b1, 32'h0000_1111, "R10");

      // R2: write precedence on the window
      acc(BUF, WD, 1'b1, 1'b1, 32'h0000_2222, "R2");
      idle("R1");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule